// File: doc/BRIEF.md
# DMA Completion Interrupt Aggregator

This block gathers end-of-transfer events from eight DMA channels that drain a shared input FIFO into memory. Each channel reports through a one-cycle strobe, raised once the final word of its transfer has been committed to memory. The strobe is not raised when that word merely leaves the FIFO. The block holds one pending flag per channel and merges all of them into one level-sensitive interrupt line. The host sees the flags as a field of a readable status word. Any read of that word clears them.

The block also screens the FIFO fill-level interrupt. That interrupt tells the host that the FIFO holds more than a set number of entries, so that core reads can empty it. When DMA is draining the FIFO, the interrupt is not wanted. The block therefore blocks it while DMA mode is active. DMA mode is active only when the global DMA enable is set and at least one per-channel enable is also set. At all other times the fill-level condition reaches the output unchanged.

Top module: `dma_done_irq_agg`

## Requirements
- R1: While reset (active-low, synchronous) is asserted and in the cycle after it, the status word reads 0 and `dmaIrq` is 0.
- R2: A strobe on `chLastDone[n]` sets the pending flag of channel n. That flag is status bit 10+n (channel 0 at bit 10, channel 7 at bit 17), and it reads 1 from the cycle after the strobe.
- R3: `dmaIrq` is 1 exactly when at least one pending flag is set.
- R4: While `rdEn` is high, `rdData` shows the pending flags as they stand before the read. From the next cycle those flags are cleared.
- R5: A strobe that arrives in the same cycle as a read is kept, so its flag still reads 1 after the read.
- R6: Status bits 31..18 and 9..0 always read 0.
- R7: When `dmaGlobalEn` is 0, or when every bit of `dmaChEn` is 0, `fifoThrIrq` equals `fifoAboveThr`.
- R8: When `dmaGlobalEn` is 1 and at least one bit of `dmaChEn` is 1, `fifoThrIrq` is 0.
- R9: When no read takes place, pending flags stay set, and new strobes add to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| dmaGlobalEn | input | 1 | Global DMA enable |
| dmaChEn | input | 8 | Per-channel DMA enables |
| chLastDone | input | 8 | Per-channel strobe: last word written to memory |
| fifoAboveThr | input | 1 | FIFO fill level above threshold |
| rdEn | input | 1 | Status register read strobe |
| rdData | output | 32 | Status word; pending flags in bits 17..10 |
| dmaIrq | output | 1 | Aggregated completion interrupt (level) |
| fifoThrIrq | output | 1 | Fill-level interrupt after DMA-mode masking |

## Verification
The assertions assume that reset is held low for at least two clock edges, so that every `$past` term refers to state that was formed after reset. They also assume that every input is driven to a known value on each edge.

The bench drives all inputs at the falling edge and holds them stable through the next rising edge. During reset it holds the strobes and the read strobe at 0. Random phases give every enable combination, including the case where the global enable is set and no channel is enabled. They also give strobes that coincide with reads.

// File: rtl/dma_done_irq_pkg.sv
package dma_done_irq_pkg;
  localparam int unsigned NUM_CH   = 8;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned FLAG_LSB = 10;

  typedef struct packed {
    logic clrPend;  // host read: clear all pending flags
    logic dmaMode;  // DMA draining active: mask fill-level interrupt
  } ctlStrobe_t;
endpackage

// File: rtl/dma_done_irq_ctl.sv
module dma_done_irq_ctl
  import dma_done_irq_pkg::*;
#(
  parameter int unsigned N_CH = NUM_CH
) (
  input  logic            rdEn,
  input  logic            dmaGlobalEn,
  input  logic [N_CH-1:0] dmaChEn,
  output ctlStrobe_t      ctl
);
  logic anyChEn;

  always_comb begin
    anyChEn = |dmaChEn;
    ctl.dmaMode = dmaGlobalEn & anyChEn;
    ctl.clrPend = rdEn;
  end
endmodule

// File: rtl/dma_done_irq_dp.sv
module dma_done_irq_dp
  import dma_done_irq_pkg::*;
#(
  parameter int unsigned N_CH   = NUM_CH,
  parameter int unsigned W      = WORD_W,
  parameter int unsigned LSB    = FLAG_LSB
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      ctl,
  input  logic [N_CH-1:0] chLastDone,
  input  logic            fifoAboveThr,
  output logic [W-1:0]    statusWord,
  output logic            irqOut,
  output logic            thrOut
);
  localparam int unsigned MSB = LSB + N_CH - 1;

  initial begin
    if (MSB >= W) $error("flag field does not fit in status word");
  end

  logic [N_CH-1:0] pend;

  // One pending flag per channel; a strobe in a read cycle wins over the clear.
  for (genvar gi = 0; gi < N_CH; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)
        pend[gi] <= 1'b0;
      else if (chLastDone[gi])
        pend[gi] <= 1'b1;
      else if (ctl.clrPend)
        pend[gi] <= 1'b0;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[MSB:LSB] = pend;
    irqOut = |pend;
    thrOut = fifoAboveThr & ~ctl.dmaMode;
  end
endmodule

// File: rtl/dma_done_irq_agg.sv
module dma_done_irq_agg
  import dma_done_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              dmaGlobalEn,
  input  logic [NUM_CH-1:0] dmaChEn,
  input  logic [NUM_CH-1:0] chLastDone,
  input  logic              fifoAboveThr,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              dmaIrq,
  output logic              fifoThrIrq
);
  ctlStrobe_t ctl;

  dma_done_irq_ctl #(.N_CH(NUM_CH)) u_ctl (
    .rdEn        (rdEn),
    .dmaGlobalEn (dmaGlobalEn),
    .dmaChEn     (dmaChEn),
    .ctl         (ctl)
  );

  dma_done_irq_dp #(.N_CH(NUM_CH), .W(WORD_W), .LSB(FLAG_LSB)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .chLastDone   (chLastDone),
    .fifoAboveThr (fifoAboveThr),
    .statusWord   (rdData),
    .irqOut       (dmaIrq),
    .thrOut       (fifoThrIrq)
  );
endmodule

// File: rtl/dma_done_irq_chk.sv
module dma_done_irq_chk
  import dma_done_irq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              dmaGlobalEn,
  input logic [NUM_CH-1:0] dmaChEn,
  input logic [NUM_CH-1:0] chLastDone,
  input logic              fifoAboveThr,
  input logic              rdEn,
  input logic [WORD_W-1:0] rdData,
  input logic              dmaIrq,
  input logic              fifoThrIrq
);
  localparam int unsigned MSB = FLAG_LSB + NUM_CH - 1;

  logic armed;
  logic [NUM_CH-1:0] flags;
  logic [WORD_W-1:0] others;

  always_ff @(posedge clk) armed <= rstN;

  always_comb begin
    flags  = rdData[MSB:FLAG_LSB];
    others = rdData;
    others[MSB:FLAG_LSB] = '0;
  end

  p_reset_clear_r1: assert property (@(posedge clk) !armed |-> ##1 (!rstN || (flags == '0 && !dmaIrq)));
  p_set_r2: assert property (@(posedge clk) disable iff (!rstN || !armed)
    1'b1 |=> ((flags & $past(chLastDone)) == $past(chLastDone)));
  p_irq_r3: assert property (@(posedge clk) disable iff (!rstN || !armed)
    dmaIrq == (flags != '0));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rstN || !armed)
    rdEn |=> (flags == $past(chLastDone)));
  p_keep_r5: assert property (@(posedge clk) disable iff (!rstN || !armed)
    (rdEn && chLastDone != '0) |=> (flags != '0));
  p_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    others == '0);
  p_pass_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(dmaGlobalEn && dmaChEn != '0) |-> (fifoThrIrq == fifoAboveThr));
  p_mask_r8: assert property (@(posedge clk) disable iff (!rstN)
    (dmaGlobalEn && dmaChEn != '0) |-> !fifoThrIrq);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN || !armed)
    !rdEn |=> (flags == ($past(flags) | $past(chLastDone))));
endmodule

bind dma_done_irq_agg dma_done_irq_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .dmaGlobalEn  (dmaGlobalEn),
  .dmaChEn      (dmaChEn),
  .chLastDone   (chLastDone),
  .fifoAboveThr (fifoAboveThr),
  .rdEn         (rdEn),
  .rdData       (rdData),
  .dmaIrq       (dmaIrq),
  .fifoThrIrq   (fifoThrIrq)
);

// File: tb/dma_done_irq_agg_tb.sv
module dma_done_irq_agg_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        dmaGlobalEn;
  logic [7:0]  dmaChEn;
  logic [7:0]  chLastDone;
  logic        fifoAboveThr;
  logic        rdEn;
  logic [31:0] rdData;
  logic        dmaIrq;
  logic        fifoThrIrq;

  int nTests = 0;
  int nFail  = 0;
  bit [7:0] refPend;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_done_irq_agg u_dut (
    .clk(clk), .rstN(rstN), .dmaGlobalEn(dmaGlobalEn), .dmaChEn(dmaChEn),
    .chLastDone(chLastDone), .fifoAboveThr(fifoAboveThr), .rdEn(rdEn),
    .rdData(rdData), .dmaIrq(dmaIrq), .fifoThrIrq(fifoThrIrq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one cycle, compare outputs against the model, then advance the model.
  task automatic step(bit g, bit [7:0] en, bit [7:0] done, bit thr, bit rd, string flagTag);
    bit dmaMode;
    @(negedge clk);
    dmaGlobalEn = g; dmaChEn = en; chLastDone = done; fifoAboveThr = thr; rdEn = rd;
    #1;
    dmaMode = g && (en != 0);
    check({flagTag, " flags"}, {24'd0, rdData[17:10]}, {24'd0, refPend});
    check("R6 other bits", {rdData[31:18], 8'd0, rdData[9:0]}, 32'd0);
    check("R3 dmaIrq", {31'd0, dmaIrq}, {31'd0, refPend != 0});
    if (dmaMode) check("R8 masked", {31'd0, fifoThrIrq}, 32'd0);
    else         check("R7 pass", {31'd0, fifoThrIrq}, {31'd0, thr});
    @(posedge clk);
    if (rd) refPend = done;
    else    refPend = refPend | done;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; dmaGlobalEn = 0; dmaChEn = 0; chLastDone = 0; fifoAboveThr = 0; rdEn = 0;
    refPend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset status", rdData, 32'd0);
    check("R1 reset irq", {31'd0, dmaIrq}, 32'd0);
    rstN = 1'b1;
    step(0, 8'h00, 8'h00, 0, 0, "R1");
    // R2: each channel maps to bit 10+n
    for (int i = 0; i < 8; i++) begin
      step(1, 8'h01, 8'h01 << i, 1, 0, "R2");
      step(1, 8'h01, 8'h00, 1, 1, "R2");
    end
    // R9: accumulation without reads
    step(0, 8'h00, 8'h05, 1, 0, "R9");
    step(0, 8'h00, 8'h80, 0, 0, "R9");
    step(1, 8'h00, 8'h00, 1, 0, "R9");
    // R4: read then cleared
    step(1, 8'hFF, 8'h00, 1, 1, "R4");
    step(1, 8'hFF, 8'h00, 1, 0, "R4");
    // R5: strobe coinciding with read is kept
    step(0, 8'h00, 8'h12, 0, 0, "R5");
    step(0, 8'h00, 8'h40, 0, 1, "R5");
    step(0, 8'h00, 8'h00, 0, 0, "R5");
    step(0, 8'h00, 8'h00, 0, 1, "R5");
    // R7/R8 corner: global on, no channel enabled
    step(1, 8'h00, 8'h00, 1, 0, "R7");
    step(0, 8'hFF, 8'h00, 1, 0, "R7");
    step(1, 8'h80, 8'h00, 1, 0, "R8");
    // random traffic
    for (int i = 0; i < 600; i++)
      step($urandom_range(0, 1), ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom),
           ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00,
           $urandom_range(0, 1), $urandom_range(0, 3) == 0, "R9");
    // reset mid-run
    @(negedge clk); rstN = 1'b0; chLastDone = 0; rdEn = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 re-reset status", rdData, 32'd0);
    rstN = 1'b1; refPend = 0;
    step(0, 8'h00, 8'h00, 0, 0, "R1");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule